// File: doc/BRIEF.md
# Status-Tagged Serial Sample Output Port

This block takes filtered 24-bit channel results from a decimation pipeline and tags each one with an 8-bit status byte. The byte holds the channel number and a time-break marker. The resulting 32-bit words wait in a small FIFO. A host reads them over a serial clock and data pair, paced by an active-low ready line and a token exchange.

In request mode the host first raises the token input. The port then pulls ready low and keeps it low until the host has clocked the FIFO empty. When the FIFO is empty the port releases ready and pulses the token output for a fixed number of clocks. In continuous mode ready follows the FIFO contents directly and no token is needed.

A time-break input marks an external event. The marker bit is placed on exactly one later sample, chosen by a programmable sample delay.

Top module: `sdo_port`

## Requirements
- R1: Each word is {status, data}. The status byte holds the channel in bits 31:30, the time-break marker in bit 29, and zeros in bits 28:24. The 24-bit sample occupies bits 23:0. The word is shifted out most significant bit first.
- R2: Words leave in the order they were accepted. The FIFO holds DEPTH (8) words, and `fifo_level` reports the number of words stored.
- R3: A sample offered while the FIFO holds DEPTH words is dropped and sets `ovf_flag`, which stays set until reset.
- R4: In request mode `rdy_n` stays high until a token arrives. While `rdy_n` is high, edges on `sclk` shift nothing and remove nothing.
- R5: In request mode, after a token, `rdy_n` goes low once data is waiting, no earlier than two clocks after the token. It stays low until the last stored word has been shifted out, and then returns high.
- R6: In request mode, `tok_out` goes high in the same cycle that `rdy_n` returns high at the end of a burst, and it stays high for exactly TOK_CYC (4) clocks.
- R7: In continuous mode `rdy_n` is low whenever the FIFO holds data, without any token, and `tok_out` stays low.
- R8: After a time-break pulse with delay D, the (D+1)-th sample accepted afterwards carries the marker. A delay of 0 marks the very next sample.
- R9: A time-break event marks exactly one sample. All other samples carry a marker of 0.
- R10: After reset `rdy_n`=1, `tok_out`=0, `fifo_level`=0 and `ovf_flag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe, one cycle per sample |
| smp_chan | input | 2 | Channel number of the sample |
| smp_data | input | 24 | Filtered sample value |
| tbrk_pulse | input | 1 | Time-break event, one cycle |
| tbrk_delay | input | DLY_W | Samples to skip before the marked one |
| mode_cont | input | 1 | 1 = continuous mode, 0 = request mode |
| tok_in | input | 1 | Token from the host, starts a request burst |
| sclk | input | 1 | Serial clock from the host; a bit advances on each rising edge |
| rdy_n | output | 1 | Active-low data-ready |
| tok_out | output | 1 | End-of-burst token pulse |
| sdata | output | 1 | Serial data, current bit of the head word |
| fifo_level | output | $clog2(DEPTH+1) | Words stored |
| ovf_flag | output | 1 | Sticky overflow indicator |

## Verification
The assertions check on every cycle the rules that need no history beyond a few cycles:
- the FIFO level stays within bounds;
- a full FIFO holds its level and raises a sticky overflow;
- nothing shifts while ready is high;
- the token pulse starts with ready high and an empty FIFO, and lasts exactly its width;
- a time-break marker clears its pending event.

Only the bench scenarios can show that word contents, bit order and FIFO ordering are correct. The same holds for which sample the delayed marker lands on, and for the difference between the request and continuous handshakes. The bench checks these against a scoreboard queue.

// File: rtl/sdo_pkg.sv
package sdo_pkg;
  localparam int CHAN_W = 2;
  localparam int DATA_W = 24;
  localparam int STAT_W = 8;
  localparam int WORD_W = STAT_W + DATA_W;
  localparam int IDX_W  = $clog2(WORD_W);

  // Status byte: channel on top, marker next, zero padding below.
  function automatic logic [STAT_W-1:0] make_status(input logic [CHAN_W-1:0] chan,
                                                    input logic marker);
    return {chan, marker, {(STAT_W-CHAN_W-1){1'b0}}};
  endfunction

  function automatic logic [WORD_W-1:0] make_word(input logic [CHAN_W-1:0] chan,
                                                  input logic marker,
                                                  input logic [DATA_W-1:0] data);
    return {make_status(chan, marker), data};
  endfunction
endpackage

// File: rtl/sdo_fifo.sv
module sdo_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [LVL_W-1:0] level,
  output logic             wr_ok,
  output logic             drop
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [LVL_W-1:0] cnt;
  logic full, empty, rd_ok;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == LVL_W'(DEPTH));
  assign empty   = (cnt == '0);
  assign wr_ok   = wr_en && !full;
  assign drop    = wr_en && full;
  assign rd_ok   = rd_en && !empty;
  assign rd_data = mem[rp];
  assign level   = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_ok) wp <= ptr_next(wp);
      if (rd_ok) rp <= ptr_next(rp);
      case ({wr_ok, rd_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_data;
  end
endmodule

// File: rtl/sdo_tbrk.sv
module sdo_tbrk #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             event_in,
  input  logic [DLY_W-1:0] delay,
  input  logic             smp_valid,
  output logic             flag_hit,
  output logic             pending
);
  logic [DLY_W-1:0] left;

  // A new event in the same cycle restarts the countdown; that sample is not counted.
  assign flag_hit = smp_valid && pending && (left == '0) && !event_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      left    <= '0;
    end else if (event_in) begin
      pending <= 1'b1;
      left    <= delay;
    end else if (smp_valid && pending) begin
      if (left == '0) pending <= 1'b0;
      else            left    <= left - 1'b1;
    end
  end
endmodule

// File: rtl/sdo_serdes.sv
module sdo_serdes import sdo_pkg::*; #(
  parameter int LVL_W   = 4,
  parameter int TOK_CYC = 4,
  localparam int TOK_W  = $clog2(TOK_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_cont,
  input  logic              tok_in,
  input  logic              sclk,
  input  logic [WORD_W-1:0] head_word,
  input  logic [LVL_W-1:0]  level,
  input  logic              push,
  output logic              pop,
  output logic              end_burst,
  output logic [IDX_W-1:0]  bit_idx,
  output logic              rdy_n,
  output logic              tok_out,
  output logic              sdata
);
  logic             sclk_d, armed, rdy_q, shift;
  logic [TOK_W-1:0] tok_cnt;

  assign shift     = rdy_q && sclk && !sclk_d;
  assign pop       = shift && (bit_idx == IDX_W'(WORD_W - 1));
  assign end_burst = pop && (level == LVL_W'(1)) && !push;
  assign sdata     = head_word[IDX_W'(WORD_W - 1) - bit_idx];
  assign rdy_n     = !rdy_q;
  assign tok_out   = (tok_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      bit_idx <= '0;
      armed   <= 1'b0;
      rdy_q   <= 1'b0;
      tok_cnt <= '0;
    end else begin
      sclk_d <= sclk;
      if (shift) bit_idx <= pop ? '0 : bit_idx + 1'b1;
      if (end_burst)                armed <= 1'b0;
      else if (tok_in && !mode_cont) armed <= 1'b1;
      rdy_q <= !end_burst && (armed || mode_cont) && (level != '0);
      if (end_burst && !mode_cont) tok_cnt <= TOK_W'(TOK_CYC);
      else if (tok_cnt != '0)      tok_cnt <= tok_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/sdo_port.sv
module sdo_port import sdo_pkg::*; #(
  parameter int DEPTH   = 8,
  parameter int DLY_W   = 16,
  parameter int TOK_CYC = 4,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [CHAN_W-1:0] smp_chan,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              tbrk_pulse,
  input  logic [DLY_W-1:0]  tbrk_delay,
  input  logic              mode_cont,
  input  logic              tok_in,
  input  logic              sclk,
  output logic              rdy_n,
  output logic              tok_out,
  output logic              sdata,
  output logic [LVL_W-1:0]  fifo_level,
  output logic              ovf_flag
);
  // Named internal events, also observed by the bound checker.
  logic              flag_hit, tb_pending;
  logic              wr_push, wr_drop, rd_pop, end_burst;
  logic [IDX_W-1:0]  bit_idx;
  logic [WORD_W-1:0] in_word, head_word;

  sdo_tbrk #(.DLY_W(DLY_W)) u_tbrk (
    .clk(clk), .rst_n(rst_n), .event_in(tbrk_pulse), .delay(tbrk_delay),
    .smp_valid(smp_valid), .flag_hit(flag_hit), .pending(tb_pending)
  );

  assign in_word = make_word(smp_chan, flag_hit, smp_data);

  sdo_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(smp_valid), .wr_data(in_word),
    .rd_en(rd_pop), .rd_data(head_word), .level(fifo_level),
    .wr_ok(wr_push), .drop(wr_drop)
  );

  sdo_serdes #(.LVL_W(LVL_W), .TOK_CYC(TOK_CYC)) u_serdes (
    .clk(clk), .rst_n(rst_n), .mode_cont(mode_cont), .tok_in(tok_in), .sclk(sclk),
    .head_word(head_word), .level(fifo_level), .push(wr_push), .pop(rd_pop),
    .end_burst(end_burst), .bit_idx(bit_idx), .rdy_n(rdy_n), .tok_out(tok_out),
    .sdata(sdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_flag <= 1'b0;
    else if (wr_drop) ovf_flag <= 1'b1;
  end
endmodule

// File: rtl/sdo_port_chk.sv
module sdo_port_chk import sdo_pkg::*; #(
  parameter int DEPTH   = 8,
  parameter int TOK_CYC = 4,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic             tbrk_pulse,
  input logic             mode_cont,
  input logic             rdy_n,
  input logic             tok_out,
  input logic [LVL_W-1:0] fifo_level,
  input logic             ovf_flag,
  input logic             rd_pop,
  input logic             flag_hit,
  input logic             tb_pending,
  input logic [IDX_W-1:0] bit_idx
);
  int hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_cnt <= 0;
    else if (tok_out) hi_cnt <= hi_cnt + 1;
    else              hi_cnt <= 0;
  end

  AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(DEPTH)); // R2
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level == LVL_W'(DEPTH) && !rd_pop) |=> fifo_level == LVL_W'(DEPTH)); // R3
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level == LVL_W'(DEPTH) && smp_valid) |=> ovf_flag); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag); // R3
  AST_NO_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_n |=> $stable(bit_idx)); // R4
  AST_TOK_AT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tok_out) |-> (rdy_n && fifo_level == '0 && !mode_cont)); // R6
  AST_TOK_MAX_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    tok_out |-> hi_cnt < TOK_CYC); // R6
  AST_TOK_FULL_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tok_out) |-> hi_cnt == TOK_CYC); // R6
  AST_MARK_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_hit && !tbrk_pulse) |=> !tb_pending); // R9
endmodule

bind sdo_port sdo_port_chk #(.DEPTH(DEPTH), .TOK_CYC(TOK_CYC)) i_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .tbrk_pulse(tbrk_pulse),
  .mode_cont(mode_cont), .rdy_n(rdy_n), .tok_out(tok_out), .fifo_level(fifo_level),
  .ovf_flag(ovf_flag), .rd_pop(rd_pop), .flag_hit(flag_hit), .tb_pending(tb_pending),
  .bit_idx(bit_idx)
);

// File: tb/test_sdo_port.sv
module test_sdo_port;
  localparam int DEPTH = 8, DLY_W = 16, TOK_CYC = 4;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0, smp_valid = 0, tbrk_pulse = 0;
  logic mode_cont = 0, tok_in = 0, sclk = 0;
  logic [1:0]       smp_chan = 0;
  logic [23:0]      smp_data = 0;
  logic [DLY_W-1:0] tbrk_delay = 0;
  wire              rdy_n, tok_out, sdata, ovf_flag;
  wire [LVL_W-1:0]  fifo_level;

  int n_chk = 0, n_fail = 0, mdl_level = 0, tb_left = -1;
  logic tok_seen = 0;
  logic [31:0] exp_q[$];

  always #10 clk = ~clk;

  sdo_port #(.DEPTH(DEPTH), .DLY_W(DLY_W), .TOK_CYC(TOK_CYC)) i_sdo_port (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_data(smp_data), .tbrk_pulse(tbrk_pulse), .tbrk_delay(tbrk_delay),
    .mode_cont(mode_cont), .tok_in(tok_in), .sclk(sclk), .rdy_n(rdy_n),
    .tok_out(tok_out), .sdata(sdata), .fifo_level(fifo_level), .ovf_flag(ovf_flag)
  );

  always @(posedge clk) if (mode_cont && tok_out) tok_seen <= 1'b1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Driver: computes the expected word and queues it when the model FIFO has room.
  task automatic push_sample(input logic [1:0] ch, input logic [23:0] d);
    logic mark;
    mark = (tb_left == 0);
    if (tb_left >= 0) tb_left--;
    if (mdl_level < DEPTH) begin
      exp_q.push_back({ch, mark, 5'b00000, d});
      mdl_level++;
    end
    @(negedge clk); smp_valid = 1; smp_chan = ch; smp_data = d;
    @(negedge clk); smp_valid = 0;
  endtask

  task automatic time_break(input int dly);
    tb_left = dly;
    @(negedge clk); tbrk_delay = DLY_W'(dly); tbrk_pulse = 1;
    @(negedge clk); tbrk_pulse = 0;
  endtask

  task automatic give_token();
    @(negedge clk); tok_in = 1;
    @(negedge clk); tok_in = 0;
    repeat (2) @(negedge clk);
  endtask

  // Monitor: clocks one word out, pops the scoreboard and compares.
  task automatic read_word(input string req);
    logic [31:0] got;
    got = '0;
    for (int b = 0; b < 32; b++) begin
      @(negedge clk); sclk = 0;
      @(negedge clk); got = {got[30:0], sdata}; sclk = 1;
      @(negedge clk);
    end
    mdl_level--;
    if (exp_q.size() == 0) begin
      n_chk++; n_fail++;
      $display("FAIL %s: actual %h expected <empty queue>", req, got);
    end else check(req, got, exp_q.pop_front());
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 rdy_n", rdy_n, 1);
    check("R10 tok_out", tok_out, 0);
    check("R10 level", fifo_level, 0);
    check("R10 ovf", ovf_flag, 0);

    // Request mode: data waits, no token yet
    push_sample(2'd0, 24'hA5C3F1);
    push_sample(2'd1, 24'h123456);
    push_sample(2'd2, 24'h800001);
    repeat (4) @(negedge clk);
    check("R4 ready held without token", rdy_n, 1);
    check("R2 level after 3 writes", fifo_level, 3);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); sclk = 1;
      @(negedge clk); sclk = 0;
    end
    @(negedge clk);
    check("R4 sclk ignored while ready high", fifo_level, 3);

    give_token();
    check("R5 ready low after token", rdy_n, 0);
    read_word("R1 R2 first word");
    check("R5 ready low mid burst", rdy_n, 0);
    check("R6 no token before empty", tok_out, 0);
    read_word("R1 R2 second word");
    read_word("R1 R2 third word");
    check("R5 ready released when empty", rdy_n, 1);
    check("R6 token rises with ready", tok_out, 1);
    w = 0;
    while (tok_out && w < 20) begin w++; @(negedge clk); end
    check("R6 token width", w, TOK_CYC);

    // Time-break delays
    time_break(2);
    push_sample(2'd3, 24'h000010);
    push_sample(2'd0, 24'h000020);
    push_sample(2'd1, 24'h000030);
    push_sample(2'd2, 24'h000040);
    time_break(0);
    push_sample(2'd1, 24'hFFFFFF);
    push_sample(2'd3, 24'h7FFFFF);
    @(negedge clk);
    check("R2 level after 6 writes", fifo_level, 6);
    give_token();
    read_word("R8 R9 delay 2 sample 1");
    read_word("R8 R9 delay 2 sample 2");
    read_word("R8 delay 2 marked sample");
    read_word("R9 after marked sample");
    read_word("R8 delay 0 marks next");
    read_word("R9 delay 0 single mark");
    repeat (8) @(negedge clk);

    // Overflow, then continuous mode drain
    for (int i = 0; i < 10; i++) push_sample(i[1:0], 24'h100000 + 24'(i));
    @(negedge clk);
    check("R3 level saturates", fifo_level, DEPTH);
    check("R3 overflow set", ovf_flag, 1);
    mode_cont = 1;
    repeat (3) @(negedge clk);
    check("R7 ready without token", rdy_n, 0);
    for (int i = 0; i < DEPTH; i++) read_word("R3 R7 kept word");
    repeat (3) @(negedge clk);
    check("R7 ready high when empty", rdy_n, 1);
    check("R7 no token in continuous", tok_seen, 0);
    check("R3 overflow sticky", ovf_flag, 1);
    check("R3 dropped words absent", exp_q.size(), 0);

    summary();
    $finish;
  end
endmodule